// File: doc/BRIEF.md
# Frame-Synchronous Window Configuration Bank

This block holds the configuration of five overlay windows for a display scan engine. Each window has two copies of its settings. Software writes and reads the pending copy over a small register bus. The scan engine sees only the active copy. The active copy of a window is refreshed from its pending copy only when a vertical sync rising edge arrives, and only while that window's hold bit is clear.

Software sets a window's hold bit, writes any number of its registers, and then clears the hold bit. The whole group is then applied together at the next frame boundary, so the scan engine never sees a half-written window. A global control word holds the five hold bits, which act at once, and the five pending DMA channel-enable bits. Each window's channel enable and window enable reach the active side at the frame boundary together with its other settings.

Top module: `frame_shadow_bank`

## Requirements
- R1: After a synchronous active-high reset, every pending register, every active output, every hold bit and every channel enable is 0, and `bus_rdata` is 0.
- R2: Window registers sit at byte-free word address `win*8 + idx` with idx 0 = buffer start, 1 = buffer end, 2 = top-left position, 3 = bottom-right position, 4 = window control word. A write with `bus_wr` high lands in the pending copy. A read with `bus_rd` high returns the pending value on `bus_rdata` after the next clock edge.
- R3: Writes to pending registers leave every active output unchanged until a vsync rising edge.
- R4: On a vsync rising edge, each window whose hold bit is clear copies all five pending registers and its pending channel enable into its active copy, visible after that clock edge.
- R5: A window whose hold bit is set keeps its active copy at a vsync rising edge. After the bit is cleared, the next vsync rising edge applies the pending values.
- R6: A write in the same cycle as the vsync rising edge goes to pending only. The active copy takes the value pending before that write, and the new value is applied at the following vsync rising edge.
- R7: Bit 0 of a window's control word is its window enable. `act_win_en` follows the active copy, so clearing the bit takes effect only at the next vsync rising edge.
- R8: The control word at address 40 holds the hold bits in bits [4:0], which take effect on the next clock edge, and the pending channel enables in bits [12:8]. It reads back as written in those fields and as 0 elsewhere. `act_chan_en` changes only at a vsync rising edge.
- R9: Vsync held high for several cycles counts as one rising edge. A write made while it stays high is not applied until the next rising edge.
- R10: Writes to unmapped addresses (idx 5 to 7 of a window, window numbers 5 and above other than address 40) change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | Vertical sync level; its rising edge marks the frame boundary |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data of the pending copy |
| act_start | output | 160 | Active buffer start, 32 bits per window |
| act_end | output | 160 | Active buffer end, 32 bits per window |
| act_topleft | output | 160 | Active top-left position, 32 bits per window |
| act_botright | output | 160 | Active bottom-right position, 32 bits per window |
| act_wctrl | output | 160 | Active window control word, 32 bits per window |
| act_win_en | output | 5 | Active window enable per window |
| act_chan_en | output | 5 | Active DMA channel enable per window |

## Verification
A read result is due one clock edge after the cycle with `bus_rd` high. The driver task queues the expected word, and the monitor compares it at the following falling edge. Active outputs change at the clock edge that first samples vsync high. Stimulus is applied at falling edges, so the bench compares the active outputs at the falling edge after the pulse: both before the edge, to show the hold, and after it, to show the load. For the same-cycle write and for the held vsync level, the bench compares the active copy and the pending copy one frame apart, checking the old value first and the new value one pulse later.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int REGS_PER_WIN = 5;
  localparam int IDX_W        = 3;
  localparam int CHAN_LSB     = 8;
  localparam int WINEN_BIT    = 0;

  typedef enum logic [IDX_W-1:0] {
    REG_START    = 3'd0,
    REG_END      = 3'd1,
    REG_TOPLEFT  = 3'd2,
    REG_BOTRIGHT = 3'd3,
    REG_WCTRL    = 3'd4
  } wreg_e;
endpackage

// File: rtl/shadow_vsync_edge.sv
module shadow_vsync_edge (
  input  logic clk,
  input  logic rst,
  input  logic vsync,
  output logic vs_edge
);
  logic vs_prev;

  always_ff @(posedge clk) begin
    if (rst) vs_prev <= 1'b0;
    else     vs_prev <= vsync;
  end

  assign vs_edge = vsync & ~vs_prev;

  // R9
  single_load_chk: assert property (@(posedge clk) disable iff (rst)
    vs_edge |=> !vs_edge);
endmodule

// File: rtl/shadow_ctrl.sv
module shadow_ctrl #(
  parameter int NUM_WIN = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [NUM_WIN-1:0] prot_wdata,
  input  logic [NUM_WIN-1:0] chan_wdata,
  output logic [NUM_WIN-1:0] protect_q,
  output logic [NUM_WIN-1:0] chan_pend_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      protect_q   <= '0;
      chan_pend_q <= '0;
    end else if (wr_en) begin
      protect_q   <= prot_wdata;
      chan_pend_q <= chan_wdata;
    end
  end

  // R8
  hold_bits_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> protect_q == $past(prot_wdata));
endmodule

// File: rtl/shadow_window.sv
module shadow_window
  import shadow_bank_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = REGS_PER_WIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] reg_sel,
  input  logic [DW-1:0]    wdata,
  input  logic             vs_edge,
  input  logic             protect,
  input  logic             chan_pend,
  output logic [NREG*DW-1:0] pend_flat,
  output logic [NREG*DW-1:0] act_flat,
  output logic             chan_act
);
  logic load;
  assign load = vs_edge & ~protect;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DW-1:0] pend_q;
    logic [DW-1:0] act_q;

    always_ff @(posedge clk) begin
      if (rst)                                    pend_q <= '0;
      else if (wr_en && reg_sel == IDX_W'(r))     pend_q <= wdata;
    end

    always_ff @(posedge clk) begin
      if (rst)       act_q <= '0;
      else if (load) act_q <= pend_q;
    end

    assign pend_flat[r*DW +: DW] = pend_q;
    assign act_flat[r*DW +: DW]  = act_q;
  end

  always_ff @(posedge clk) begin
    if (rst)       chan_act <= 1'b0;
    else if (load) chan_act <= chan_pend;
  end

  // R3
  hold_between_frames_chk: assert property (@(posedge clk) disable iff (rst)
    !vs_edge |=> $stable(act_flat) && $stable(chan_act));

  // R4
  load_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (vs_edge && !protect) |=> act_flat == $past(pend_flat));

  // R5
  protect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vs_edge && protect) |=> $stable(act_flat));
endmodule

// File: rtl/frame_shadow_bank.sv
module frame_shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int DW      = 32,
  parameter int ADDR_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  vsync,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic [NUM_WIN*DW-1:0] act_start,
  output logic [NUM_WIN*DW-1:0] act_end,
  output logic [NUM_WIN*DW-1:0] act_topleft,
  output logic [NUM_WIN*DW-1:0] act_botright,
  output logic [NUM_WIN*DW-1:0] act_wctrl,
  output logic [NUM_WIN-1:0]    act_win_en,
  output logic [NUM_WIN-1:0]    act_chan_en
);
  localparam int WSEL_W = ADDR_W - IDX_W;
  localparam int NREG   = REGS_PER_WIN;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_WIN * (1 << IDX_W));

  logic [WSEL_W-1:0] win_sel;
  logic [IDX_W-1:0]  idx_sel;
  logic              win_hit;
  logic              ctrl_hit;
  logic              vs_edge;
  logic [NUM_WIN-1:0] protect_q;
  logic [NUM_WIN-1:0] chan_pend_q;
  logic [NREG*DW-1:0] pend_w [NUM_WIN];
  logic [NREG*DW-1:0] act_w  [NUM_WIN];
  logic [DW-1:0]      ctrl_word;
  logic [DW-1:0]      rd_mux;

  assign win_sel  = bus_addr[ADDR_W-1:IDX_W];
  assign idx_sel  = bus_addr[IDX_W-1:0];
  assign win_hit  = (int'(win_sel) < NUM_WIN) && (int'(idx_sel) < NREG);
  assign ctrl_hit = (bus_addr == CTRL_ADDR);

  shadow_vsync_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .vsync   (vsync),
    .vs_edge (vs_edge)
  );

  shadow_ctrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (bus_wr && ctrl_hit),
    .prot_wdata  (bus_wdata[NUM_WIN-1:0]),
    .chan_wdata  (bus_wdata[CHAN_LSB +: NUM_WIN]),
    .protect_q   (protect_q),
    .chan_pend_q (chan_pend_q)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    shadow_window #(.DW(DW), .NREG(NREG)) u_win (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (bus_wr && win_hit && win_sel == WSEL_W'(w)),
      .reg_sel   (idx_sel),
      .wdata     (bus_wdata),
      .vs_edge   (vs_edge),
      .protect   (protect_q[w]),
      .chan_pend (chan_pend_q[w]),
      .pend_flat (pend_w[w]),
      .act_flat  (act_w[w]),
      .chan_act  (act_chan_en[w])
    );

    assign act_start[w*DW +: DW]    = act_w[w][int'(REG_START)*DW    +: DW];
    assign act_end[w*DW +: DW]      = act_w[w][int'(REG_END)*DW      +: DW];
    assign act_topleft[w*DW +: DW]  = act_w[w][int'(REG_TOPLEFT)*DW  +: DW];
    assign act_botright[w*DW +: DW] = act_w[w][int'(REG_BOTRIGHT)*DW +: DW];
    assign act_wctrl[w*DW +: DW]    = act_w[w][int'(REG_WCTRL)*DW    +: DW];
    assign act_win_en[w]            = act_w[w][int'(REG_WCTRL)*DW + WINEN_BIT];
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[NUM_WIN-1:0]        = protect_q;
    ctrl_word[CHAN_LSB +: NUM_WIN] = chan_pend_q;
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_hit)
      rd_mux = ctrl_word;
    else if (win_hit)
      rd_mux = pend_w[int'(win_sel)][int'(idx_sel)*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !win_hit && !ctrl_hit) |=> bus_rdata == '0);

  // R8
  chan_frame_sync_chk: assert property (@(posedge clk) disable iff (rst)
    !vs_edge |=> $stable(act_chan_en));
endmodule

// File: tb/sim_frame_shadow_bank.sv
module sim_frame_shadow_bank;
  localparam int PERIOD = 10;
  localparam int NW = 5;
  localparam int DW = 32;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vsync = 1'b0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NW*DW-1:0] act_start, act_end, act_topleft, act_botright, act_wctrl;
  logic [NW-1:0] act_win_en, act_chan_en;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_seen = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  frame_shadow_bank #(.NUM_WIN(NW), .DW(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .vsync(vsync), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .act_start(act_start), .act_end(act_end), .act_topleft(act_topleft),
    .act_botright(act_botright), .act_wctrl(act_wctrl),
    .act_win_en(act_win_en), .act_chan_en(act_chan_en)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // scoreboard monitor: read data due one edge after the strobe
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic check(input string t, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, input logic [DW-1:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = AW'(addr);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse();
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] fld(input logic [NW*DW-1:0] v, input int w);
    return v[w*DW +: DW];
  endfunction

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 start0", fld(act_start, 0), '0);
    check("R1 chan", {27'd0, act_chan_en}, '0);
    check("R1 rdata", bus_rdata, '0);
    rd(40, 32'h0, "R1 ctrl");

    // R2 pending write/read, R3 active untouched
    wr(0, 32'h1000_0000); wr(1, 32'h1000_8000); wr(2, 32'h0010_0020);
    wr(3, 32'h0110_0220); wr(4, 32'h0000_0031);
    rd(0, 32'h1000_0000, "R2 start");
    rd(3, 32'h0110_0220, "R2 botright");
    rd(4, 32'h0000_0031, "R2 wctrl");
    check("R3 start before vsync", fld(act_start, 0), '0);
    check("R3 wctrl before vsync", fld(act_wctrl, 0), '0);

    // R4 load at vsync
    pulse();
    check("R4 start", fld(act_start, 0), 32'h1000_0000);
    check("R4 end", fld(act_end, 0), 32'h1000_8000);
    check("R4 topleft", fld(act_topleft, 0), 32'h0010_0020);
    check("R4 botright", fld(act_botright, 0), 32'h0110_0220);
    check("R7 enable on", {27'd0, act_win_en}, 32'h1);

    // R5 hold bit on window 1
    wr(40, 32'h0000_0002);
    wr(8, 32'hAAAA_0001); wr(12, 32'h1);
    pulse();
    check("R5 held start", fld(act_start, 1), '0);
    check("R5 held enable", {27'd0, act_win_en}, 32'h1);
    wr(40, 32'h0);
    check("R5 cleared no edge", fld(act_start, 1), '0);
    pulse();
    check("R5 applied", fld(act_start, 1), 32'hAAAA_0001);
    check("R5 enable", {27'd0, act_win_en}, 32'h3);

    // R8 channel enables
    wr(40, 32'h0000_0400);
    rd(40, 32'h0000_0400, "R8 ctrl readback");
    check("R8 chan before", {27'd0, act_chan_en}, '0);
    pulse();
    check("R8 chan after", {27'd0, act_chan_en}, 32'h4);

    // R7 disable waits for vsync
    wr(4, 32'h0);
    check("R7 still on", {27'd0, act_win_en}, 32'h3);
    pulse();
    check("R7 off", {27'd0, act_win_en}, 32'h2);

    // R6 write in the vsync edge cycle
    vsync = 1'b1; bus_wr = 1'b1; bus_addr = AW'(24); bus_wdata = 32'h3333_0000;
    @(negedge clk);
    vsync = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
    check("R6 old active", fld(act_start, 3), '0);
    rd(24, 32'h3333_0000, "R6 pending");
    pulse();
    check("R6 next frame", fld(act_start, 3), 32'h3333_0000);

    // R9 held vsync loads once
    vsync = 1'b1;
    @(negedge clk);
    wr(32, 32'h4444_0004);
    repeat (3) @(negedge clk);
    check("R9 held no load", fld(act_start, 4), '0);
    vsync = 1'b0;
    @(negedge clk);
    check("R9 fall no load", fld(act_start, 4), '0);
    pulse();
    check("R9 next edge", fld(act_start, 4), 32'h4444_0004);

    // R10 unmapped
    wr(5, 32'hDEAD_BEEF);
    rd(5, 32'h0, "R10 idx5");
    wr(48, 32'hDEAD_BEEF);
    rd(48, 32'h0, "R10 win6");
    rd(63, 32'h0, "R10 top addr");
    rd(0, 32'h1000_0000, "R10 neighbour intact");
    rd(40, 32'h0000_0400, "R10 ctrl intact");
    pulse();
    check("R10 active intact", fld(act_start, 0), 32'h1000_0000);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule